// File: doc/BRIEF.md
# Chip-Select Segment Window Decoder

This block maps bus addresses inside a flash mapping aperture onto one of several chip-select windows. Each chip select owns one segment register. The register holds a start boundary and an end boundary, both counted in 8 MB units. An address hits a chip select when its 8 MB unit lies in the range from that window's start up to, but not including, its end. The block then raises that chip select's one-hot line and gives the byte offset of the address inside the window.

The start boundary of chip select 0 fixes the physical base of the whole aperture. The aperture spans `APERTURE_UNITS` units from that base. A write that would place a window end beyond the aperture is refused, and the register keeps its previous contents. Software can read the register back to see that the write was refused.

A window whose start is not below its end is closed and never decodes. When windows overlap, the lowest-numbered chip select wins. An address that hits no open window raises a miss flag, and no chip select is asserted.

Top module: `seg_window_decoder`

## Requirements
- R1: After reset every segment register reads zero, `cs_sel` is zero and `miss` is 1.
- R2: The segment register of chip select i sits at byte offset 0x30 + 4*i. Its end boundary is in bits 31:24 and its start boundary in bits 23:16. Bits 15:0 always read zero. Unaligned offsets, offsets below 0x30 and offsets past the last chip select read zero, and writes to them change nothing.
- R3: A write is stored at the next clock edge when the new end is at most base + `APERTURE_UNITS`. The base is the current chip select 0 start. For a write to chip select 0, the base is the newly written start.
- R4: A write whose end exceeds that limit is refused, and the register keeps its previous value.
- R5: A closed window (start >= end) never asserts its chip select.
- R6: Address bits 30:23 give the address unit. An address hits chip select i when its unit is within [start_i, end_i) and also within [base, base + `APERTURE_UNITS`). Addresses outside the aperture miss.
- R7: `cs_sel` has at most one bit set. On overlapping windows, the lowest-numbered hit wins.
- R8: When no window hits, `miss` is 1, `cs_sel` is zero and `win_offset` is zero.
- R9: On a hit, `win_offset` equals the address minus start_i * 8 MB.
- R10: Decode and readback are combinational on the stored registers. A register write in the same cycle as a lookup takes effect on decode only after the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the register at `reg_addr` |
| addr_in | input | UNIT_SHIFT+8 | Bus address to decode |
| cs_sel | output | NUM_CS | One-hot chip-select match |
| miss | output | 1 | No open window contains `addr_in` |
| win_offset | output | UNIT_SHIFT+8 | Offset of `addr_in` inside the selected window |

## Verification
A register write and an address lookup can happen in the same cycle. The write can even move the very window that the address falls in, including a move of the chip select 0 base. The bench provokes this with directed cycles that rewrite chip select 0 while it looks up an address that the rewrite would move into another window. It also mixes random writes and random lookups on every cycle. In each cycle the decode is judged against a bench model that still holds the old register values, and the new values are checked only after the edge.

// File: rtl/seg_window_decoder.sv
module seg_window_decoder #(
  parameter int         NUM_CS         = 5,
  parameter int         UNIT_SHIFT     = 23,
  parameter int         APERTURE_UNITS = 32,
  parameter logic [7:0] REG_BASE       = 8'h30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [7:0]              reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [UNIT_SHIFT+7:0]   addr_in,
  output logic [NUM_CS-1:0]       cs_sel,
  output logic                    miss,
  output logic [UNIT_SHIFT+7:0]   win_offset
);
  localparam int FW = 8;
  localparam logic [FW:0] AP = (FW+1)'(APERTURE_UNITS);

  logic [FW-1:0] seg_s [NUM_CS];
  logic [FW-1:0] seg_e [NUM_CS];

  wire [7:0]    rel     = reg_addr - REG_BASE;
  wire [5:0]    idx     = rel[7:2];
  wire          reg_hit = (reg_addr >= REG_BASE) && (rel[1:0] == 2'b00) && (idx < 6'(NUM_CS));
  wire [FW-1:0] new_s   = reg_wdata[23:16];
  wire [FW-1:0] new_e   = reg_wdata[31:24];
  wire [FW:0]   lim_cur = {1'b0, seg_s[0]} + AP;
  wire [FW:0]   lim_wr  = (idx == 6'd0) ? ({1'b0, new_s} + AP) : lim_cur;
  wire          accept  = reg_wr && reg_hit && ({1'b0, new_e} <= lim_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        seg_s[i] <= '0;
        seg_e[i] <= '0;
      end
    end else if (accept) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (idx == 6'(i)) begin
          seg_s[i] <= new_s;
          seg_e[i] <= new_e;
        end
      end
    end
  end

  wire [FW-1:0] unit  = addr_in[UNIT_SHIFT+7 -: FW];
  wire          in_ap = (unit >= seg_s[0]) && ({1'b0, unit} < lim_cur);
  logic [NUM_CS-1:0] match;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    assign match[g] = in_ap && (seg_s[g] < seg_e[g]) && (unit >= seg_s[g]) && (unit < seg_e[g]);

    assert_closed_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_s[g] >= seg_e[g]) |-> !cs_sel[g]);

    assert_reject_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_hit && idx == 6'(g) && !accept) |=> ($stable(seg_s[g]) && $stable(seg_e[g])));

    assert_accept_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && idx == 6'(g)) |=> (seg_s[g] == $past(reg_wdata[23:16]) && seg_e[g] == $past(reg_wdata[31:24])));
  end

  assign cs_sel = match & (~match + NUM_CS'(1));
  assign miss   = ~|match;

  always_comb begin
    win_offset = '0;
    for (int i = NUM_CS - 1; i >= 0; i--)
      if (match[i]) win_offset = {unit - seg_s[i], addr_in[UNIT_SHIFT-1:0]};
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CS; i++)
      if (reg_hit && idx == 6'(i)) reg_rdata = {seg_e[i], seg_s[i], 16'h0000};
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_sel));

  assert_miss_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> (cs_sel == '0 && win_offset == '0));

  assert_hit_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_sel != '0) |-> !miss);

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[15:0] == 16'h0000);
endmodule

// File: tb/seg_window_decoder_bench.sv
`timescale 1ns/1ps
module seg_window_decoder_bench;
  localparam int NCS = 5;
  localparam int AP  = 32;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [30:0] addr_in = 0;
  logic [NCS-1:0] cs_sel;
  logic        miss;
  logic [30:0] win_offset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int ms [NCS];
  int me [NCS];

  always #2.5 clk = ~clk;

  seg_window_decoder u_seg_window_decoder (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_in(addr_in),
    .cs_sel(cs_sel), .miss(miss), .win_offset(win_offset));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int mslot(input logic [7:0] off);
    if (off < 8'h30 || off[1:0] != 2'b00 || int'((off - 8'h30) >> 2) >= NCS) return -1;
    return int'((off - 8'h30) >> 2);
  endfunction

  function automatic int mread(input logic [7:0] off);
    int k = mslot(off);
    if (k < 0) return 0;
    return (me[k] << 24) | (ms[k] << 16);
  endfunction

  task automatic mwrite(input logic [7:0] off, input logic [31:0] wd);
    int k = mslot(off);
    int s = int'(wd[23:16]);
    int e = int'(wd[31:24]);
    int lim;
    if (k < 0) return;
    lim = (k == 0) ? s + AP : ms[0] + AP;
    if (e <= lim) begin ms[k] = s; me[k] = e; end
  endtask

  task automatic mdec(input logic [30:0] a, output int ecs, output int em, output int eoff);
    int u = int'(a[30:23]);
    ecs = 0; em = 1; eoff = 0;
    if (u >= ms[0] && u < ms[0] + AP)
      for (int i = 0; i < NCS; i++)
        if (em == 1 && ms[i] < me[i] && u >= ms[i] && u < me[i]) begin
          ecs = 1 << i; em = 0; eoff = ((u - ms[i]) << 23) | int'(a[22:0]);
        end
  endtask

  function automatic logic [31:0] sv(input int s, input int e);
    return {8'(e), 8'(s), 16'h0000};
  endfunction

  task automatic step(input bit wr, input logic [7:0] off, input logic [31:0] wd,
                      input logic [30:0] a, input string tag);
    int ecs, em, eoff;
    @(negedge clk);
    reg_wr = wr; reg_addr = off; reg_wdata = wd; addr_in = a;
    #1;
    mdec(a, ecs, em, eoff);
    chk({tag, " R7 cs_sel"}, int'(cs_sel), ecs);
    chk({tag, " R8 miss"}, int'(miss), em);
    chk({tag, " R9 offset"}, int'(win_offset), eoff);
    chk({tag, " R2 readback"}, int'(reg_rdata), mread(off));
    @(posedge clk);
    if (wr) mwrite(off, wd);
  endtask

  task automatic look(input logic [30:0] a, input int ecs, input int em, input int eoff, input string tag);
    @(negedge clk);
    reg_wr = 0; addr_in = a;
    #1;
    chk({tag, " cs_sel"}, int'(cs_sel), ecs);
    chk({tag, " miss"}, int'(miss), em);
    chk({tag, " offset"}, int'(win_offset), eoff);
  endtask

  task automatic rd(input logic [7:0] off, input int exp, input string tag);
    @(negedge clk);
    reg_wr = 0; reg_addr = off;
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  function automatic logic [30:0] ad(input int u, input int low);
    return {8'(u), 23'(low)};
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NCS; i++) begin ms[i] = 0; me[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk("R1 miss after reset", int'(miss), 1);
    chk("R1 cs_sel after reset", int'(cs_sel), 0);
    rst_n = 1;
    for (int i = 0; i < NCS; i++) rd(8'(8'h30 + 4*i), 0, "R1 reset readback");

    step(1, 8'h30, sv(0, 8),   ad(0, 0), "R3 setup cs0");
    step(1, 8'h34, sv(8, 16),  ad(0, 0), "R3 setup cs1");
    step(1, 8'h38, sv(16, 24), ad(0, 0), "R3 setup cs2");
    step(1, 8'h3C, sv(24, 32), ad(0, 0), "R3 setup cs3");
    step(1, 8'h40, sv(32, 32), ad(0, 0), "R5 setup cs4 closed");
    rd(8'h3C, 32'h2018_0000, "R2 field layout cs3");
    look(ad(3, 'h55), 1, 0, (3 << 23) | 'h55, "R6 R9 cs0 hit");
    look(ad(8, 'h123), 2, 0, 'h123, "R9 cs1 lower edge");
    look(ad(31, 'h7FFFFF), 8, 0, (7 << 23) | 'h7FFFFF, "R6 cs3 top unit");
    look(ad(32, 0), 0, 1, 0, "R5 R6 beyond aperture");

    step(1, 8'h38, sv(16, 40), ad(0, 0), "R4 reject write");
    rd(8'h38, 32'h1810_0000, "R4 value kept");

    step(1, 8'h34, sv(4, 12), ad(0, 0), "R3 overlap setup");
    look(ad(5, 9), 1, 0, (5 << 23) | 9, "R7 lowest wins");
    look(ad(9, 0), 2, 0, 5 << 23, "R7 cs1 after overlap");

    step(1, 8'h2C, sv(1, 2), ad(0, 0), "R2 below base");
    step(1, 8'h32, sv(1, 2), ad(0, 0), "R2 unaligned");
    step(1, 8'h44, sv(1, 2), ad(0, 0), "R2 past last");
    rd(8'h30, 32'h0800_0000, "R2 cs0 untouched");
    rd(8'h44, 0, "R2 past last reads zero");
    step(1, 8'h40, sv(32, 32) | 32'hFFFF, ad(0, 0), "R2 low bits written");
    rd(8'h40, 32'h2020_0000, "R2 low bits read zero");

    step(1, 8'h30, sv(0, 2), ad(5, 0), "R10 same cycle old value");
    look(ad(5, 0), 2, 0, 1 << 23, "R10 new value after edge");

    step(1, 8'h30, sv(4, 6), ad(0, 0), "R3 rebase");
    look(ad(2, 0), 0, 1, 0, "R6 below base");
    look(ad(35, 0), 0, 1, 0, "R6 above rebased window");

    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 5);
      logic [7:0] off = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'(8'h30 + 4*k);
      logic [31:0] wd = {8'($urandom_range(0, 47)), 8'($urandom_range(0, 40)), 16'($urandom)};
      step(bit'($urandom_range(0, 1)), off, wd, ad($urandom_range(0, 47), int'($urandom)), "R3 R4 R6 random");
    end

    @(negedge clk);
    reg_wr = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule